// File: doc/BRIEF.md
# Dual-Output Power-Good Monitor

This block produces the power-good indication for a pair of regulated outputs. Each output has an analog comparator that reports whether it is above 90% of its set point. The two comparator flags arrive asynchronously. The block also takes a device-running state and a low-power mode flag from the surrounding control logic, both in the clock domain. The result is a single drive-low enable for an open-drain pad. When the enable is high the pad is pulled low. When it is low the pad floats and an external pull-up sets the level.

While the device runs in normal mode, the block pulls the pin low until both channels are good and a startup delay has passed. Either channel dropping pulls the pin low again at once. When the device is stopped, or is in low-power mode, the pin floats whatever the comparators say.

Top module: `pgood_monitor`

## Requirements
- R1: After reset, with the device stopped, the drive-low enable `pg_pull_low_o` is 0 (pin released).
- R2: While the device runs and low power is off, `pg_pull_low_o` is 1 whenever either synchronized good flag is 0.
- R3: Release requires both flags to be good. It happens exactly SYNC_STAGES + DELAY_TICKS clock edges after the second flag rises at the input, provided the device kept running in normal mode throughout. At the default of 1500 ticks at 1 MHz this stays below 2 ms.
- R4: When `dev_run_i` is 0, `pg_pull_low_o` is 0 in the same cycle, regardless of the flags.
- R5: When `low_power_i` is 1, `pg_pull_low_o` is 0 in the same cycle, regardless of the flags.
- R6: After release, a good flag falling pulls the pin low as soon as the fall leaves the synchronizer, SYNC_STAGES edges after the input change, with no extra delay.
- R7: If either synchronized flag drops during the delay window, the count restarts from zero. Release then comes a full SYNC_STAGES + DELAY_TICKS edges after the flag returns.
- R8: Leaving low-power mode with both flags already good keeps the pin low for exactly DELAY_TICKS edges before release.
- R9: Each channel alone holds the pin low: channel A good with B bad, or B good with A bad, never releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_run_i | input | 1 | Device running (either output enable active), clock domain |
| low_power_i | input | 1 | Low-power mode active, clock domain |
| good_a_i | input | 1 | Channel A above 90% of set point, asynchronous |
| good_b_i | input | 1 | Channel B above 90% of set point, asynchronous |
| pg_pull_low_o | output | 1 | 1 = drive the pad low, 0 = release to high impedance |

## Verification
The bench builds the block with DELAY_TICKS = 20 and SYNC_STAGES = 2. A full release then takes 22 edges, so each release and each restarted window can be checked on the exact edge where it must happen, and also one edge earlier. The short window leaves room to interrupt the count part-way. This separates a design that restarts the count from one that only pauses it, and shows whether the delay is re-armed when low-power mode ends.

// File: rtl/pgood_pkg.sv
// Shared types for the power-good monitor.
// Assumes: two monitored channels, release sequencing encoded in a small enum.
package pgood_pkg;

    localparam int unsigned PG_NUM_CH = 2;

    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,   // device stopped or low power: pin floats
        PG_WAIT = 2'd1,   // running, counting toward release
        PG_OK   = 2'd2    // released, both channels good
    } pg_state_e;

endpackage

// File: rtl/pgood_sync.sv
// Multi-stage synchronizer for the asynchronous comparator flags.
// Assumes: each flag is a level that changes slowly; a reset to zero reads as "not good".
module pgood_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stg [STAGES];

    // Shift each flag through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/pgood_delay.sv
// Release sequencer: counts DELAY_TICKS consecutive cycles of "active and both good"
// before declaring release, and restarts on any interruption.
// Assumes: DELAY_TICKS >= 2; inputs are already synchronous.
module pgood_delay
    import pgood_pkg::*;
#(
    parameter int unsigned DELAY_TICKS = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic both_good_i,
    output logic released_o
);

    localparam int unsigned CNT_W = $clog2(DELAY_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

    pg_state_e        state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    // Next-state and counter update for the release window.
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (!active_i) begin
            state_n = PG_IDLE;
            cnt_n   = '0;
        end else if (!both_good_i) begin
            state_n = PG_WAIT;
            cnt_n   = '0;
        end else if (state_q != PG_OK) begin
            if (cnt_q == LAST) begin
                state_n = PG_OK;
                cnt_n   = '0;
            end else begin
                state_n = PG_WAIT;
                cnt_n   = cnt_q + 1'b1;
            end
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PG_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    assign released_o = (state_q == PG_OK);

    // R3
    release_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(released_o) |-> $past(cnt_q) == LAST);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R6
    drop_leaves_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        released_o && !both_good_i |=> !released_o);

endmodule

// File: rtl/pgood_monitor.sv
// Dual-output power-good monitor: synchronizes the two comparator flags,
// sequences the startup delay and drives the open-drain pull-down enable.
// Assumes: dev_run_i and low_power_i are in the clk domain; the pad floats when
// pg_pull_low_o is 0.
module pgood_monitor #(
    parameter int unsigned DELAY_TICKS = 1500,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dev_run_i,
    input  logic low_power_i,
    input  logic good_a_i,
    input  logic good_b_i,
    output logic pg_pull_low_o
);

    import pgood_pkg::*;

    logic [PG_NUM_CH-1:0] good_sync;
    logic                 both_good;
    logic                 active;
    logic                 released;

    pgood_sync #(
        .WIDTH  (PG_NUM_CH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({good_b_i, good_a_i}),
        .sync_o  (good_sync)
    );

    // Both channels good once synchronized; monitoring only in normal run mode.
    assign both_good = &good_sync;
    assign active    = dev_run_i && !low_power_i;

    pgood_delay #(
        .DELAY_TICKS (DELAY_TICKS)
    ) u_delay (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (active),
        .both_good_i (both_good),
        .released_o  (released)
    );

    // Pull low while active unless released and still good (immediate drop).
    assign pg_pull_low_o = active && !(released && both_good);

    // R2
    release_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        released && active && !pg_pull_low_o |-> good_sync[0] && good_sync[1]);

    // R4
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_run_i |=> !released);

    // R5
    low_power_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_power_i |=> !released);

endmodule

// File: tb/tb_pgood_monitor.sv
module tb_pgood_monitor;

    localparam int unsigned DLY  = 20;
    localparam int unsigned SYNC = 2;

    logic clk = 1'b0;
    logic rst_n, run, lp, ga, gb;
    logic pull_low;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    always #10 clk = ~clk;

    pgood_monitor #(.DELAY_TICKS(DLY), .SYNC_STAGES(SYNC)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .dev_run_i     (run),
        .low_power_i   (lp),
        .good_a_i      (ga),
        .good_b_i      (gb),
        .pg_pull_low_o (pull_low)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic exp);
        #1;
        checks++;
        if (pull_low !== exp) begin
            errors++;
            $display("FAIL %s: pg_pull_low_o actual=%b expected=%b", req, pull_low, exp);
        end
    endtask

    // R1: reset state with device stopped
    task automatic t_reset();
        rst_n = 0; run = 0; lp = 0; ga = 0; gb = 0;
        tick(3);
        rst_n = 1;
        tick(1);
        chk("R1", 1'b0);
    endtask

    // R2, R9: running with one or both channels bad
    task automatic t_hold();
        run = 1; ga = 0; gb = 0;
        tick(1);
        chk("R2", 1'b1);
        ga = 1; gb = 0;
        tick(SYNC + DLY + 5);
        chk("R9", 1'b1);
        ga = 0; gb = 1;
        tick(SYNC + DLY + 5);
        chk("R9", 1'b1);
    endtask

    // R3: release exactly after sync plus delay
    task automatic t_release();
        ga = 1;
        tick(SYNC + DLY - 1);
        chk("R3", 1'b1);
        tick(1);
        chk("R3", 1'b0);
    endtask

    // R6: drop after release pulls low after sync latency only
    task automatic t_drop();
        ga = 0;
        tick(SYNC - 1);
        chk("R6", 1'b0);
        tick(1);
        chk("R6", 1'b1);
        ga = 1;
        tick(SYNC + DLY);
        chk("R3", 1'b0);
    endtask

    // R7: interruption inside the window restarts the count
    task automatic t_restart();
        gb = 0;
        tick(SYNC + 3);
        chk("R2", 1'b1);
        gb = 1;
        tick(SYNC + 5);
        gb = 0;
        tick(1);
        gb = 1;
        tick(SYNC + DLY - 1);
        chk("R7", 1'b1);
        tick(1);
        chk("R7", 1'b0);
    endtask

    // R5, R8: low-power mode floats the pin and re-arms the delay
    task automatic t_lowpower();
        lp = 1;
        tick(1);
        chk("R5", 1'b0);
        ga = 0; gb = 0;
        tick(5);
        chk("R5", 1'b0);
        ga = 1; gb = 1;
        tick(5);
        chk("R5", 1'b0);
        lp = 0;
        tick(DLY - 1);
        chk("R8", 1'b1);
        tick(1);
        chk("R8", 1'b0);
    endtask

    // R4: stopped device floats the pin
    task automatic t_stop();
        run = 0;
        tick(1);
        chk("R4", 1'b0);
        ga = 0;
        tick(5);
        chk("R4", 1'b0);
        run = 1;
        tick(1);
        chk("R2", 1'b1);
    endtask

    initial begin
        t_reset();
        t_hold();
        t_release();
        t_drop();
        t_restart();
        t_lowpower();
        t_stop();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule